// File: doc/BRIEF.md
# Segmented Thermometer Code Decoder

This block turns a binary sample into the switch controls of a segmented current-steering converter. The sample is cut into two parts. The upper part is expanded into a unary thermometer code, with one line for each equal-weight current cell. The lower part stays binary and drives the binary-weighted cells.

The unary expansion runs in two pipelined steps. First the upper field is split into two narrower fields, and each of them is decoded and registered on its own. The second step combines these into the full set of thermometer lines. The binary part passes through a delay line of the same length, so both parts leave in the same cycle. A final register aligns every control line to one clock edge, which keeps the skew between switch controls small.

With the default parameters the sample is 12 bits wide. It yields 63 unary lines and 6 binary lines, and a new sample can enter on every clock.

Top module: `seg_therm_decoder`

## Requirements
- R1: The input word is split at a fixed boundary. Bits [11:6] form the unary field N, and bits [5:0] form the binary field.
- R2: For unary field value N, thermometer line k (therm_o[k], for k from 0 to 62) is high exactly when k < N.
- R3: A word presented before rising edge t appears on therm_o after rising edge t+2, which is three register stages. Before that edge, therm_o still shows the previous word.
- R4: bin_o equals the binary field of the input word unchanged, with the same three-stage latency as therm_o.
- R5: The unary and binary fields of one input word appear on the outputs in the same cycle.
- R6: While rst_n is low, all therm_o and bin_o lines are low.
- R7: A new word accepted on every clock edge produces one matching output word per clock, in input order.
- R8: N = 0 drives all 63 lines low, and N = 63 drives all 63 lines high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| data_i | input | 12 | Binary sample |
| therm_o | output | 63 | Unary thermometer lines |
| bin_o | output | 6 | Binary-weighted lines |

## Verification
Single words are applied at the extremes N=0 and N=63, and at values one step away from them. These separate a missing line from a stuck line. Values on both sides of every multiple of eight are also applied. They cross the boundary between the two 3-bit fields, so a wrong row-equality term or a swapped field shows up there.

A word whose two fields change together tells a mismatched binary delay apart from a mismatched unary delay. A back-to-back stream of distinct words shows whether samples are dropped or reordered. A reset applied in the middle of a stream checks the clearing behaviour.

// File: rtl/segdec_pkg.sv
package segdec_pkg;
   localparam int DEF_DATA_W = 12;
   localparam int DEF_MSB_W  = 6;

   function automatic int unary_lines(input int w);
      return (1 << w) - 1;
   endfunction
endpackage

// File: rtl/segdec_field.sv
module segdec_field #(
   parameter int W = 3
) (
   input  logic [W-1:0]        code_i,
   output logic [(1<<W)-2:0]   lines_o
);
   localparam int LINES = (1 << W) - 1;

   for (genvar g = 0; g < LINES; g++) begin : g_line
      assign lines_o[g] = (32'(code_i) > g);
   end
endmodule

// File: rtl/segdec_delay.sv
module segdec_delay #(
   parameter int WIDTH = 6,
   parameter int DEPTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (DEPTH == 0) begin : g_wire
      assign q_o = d_i;
   end else begin : g_regs
      logic [WIDTH-1:0] tap [DEPTH];
      for (genvar s = 0; s < DEPTH; s++) begin : g_tap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      tap[s] <= '0;
            else if (s == 0) tap[s] <= d_i;
            else             tap[s] <= tap[s-1];
         end
      end
      assign q_o = tap[DEPTH-1];
   end
endmodule

// File: rtl/segdec_merge.sv
module segdec_merge #(
   parameter int ROW_W = 3,
   parameter int COL_W = 3
) (
   input  logic [(1<<ROW_W)-2:0]         rows_i,
   input  logic [(1<<COL_W)-2:0]         cols_i,
   output logic [(1<<(ROW_W+COL_W))-2:0] lines_o
);
   localparam int ROWS  = 1 << ROW_W;
   localparam int COLS  = 1 << COL_W;
   localparam int LINES = ROWS * COLS - 1;

   for (genvar i = 0; i < ROWS; i++) begin : g_row
      logic full_row, edge_row;
      if (i < ROWS - 1) begin : g_full
         assign full_row = rows_i[i];
      end else begin : g_none
         assign full_row = 1'b0;
      end
      if (i == 0) begin : g_eq_first
         assign edge_row = ~rows_i[0];
      end else if (i == ROWS - 1) begin : g_eq_last
         assign edge_row = rows_i[i-1];
      end else begin : g_eq_mid
         assign edge_row = rows_i[i-1] & ~rows_i[i];
      end
      for (genvar j = 0; j < COLS; j++) begin : g_col
         if (i * COLS + j < LINES) begin : g_used
            if (j < COLS - 1) begin : g_part
               assign lines_o[i*COLS+j] = full_row | (edge_row & cols_i[j]);
            end else begin : g_tail
               assign lines_o[i*COLS+j] = full_row;
            end
         end
      end
   end
endmodule

// File: rtl/seg_therm_decoder.sv
module seg_therm_decoder
   import segdec_pkg::*;
#(
   parameter int DATA_W = DEF_DATA_W,
   parameter int MSB_W  = DEF_MSB_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [DATA_W-1:0]            data_i,
   output logic [(1<<MSB_W)-2:0]        therm_o,
   output logic [DATA_W-MSB_W-1:0]      bin_o
);
   localparam int LSB_W   = DATA_W - MSB_W;
   localparam int LO_W    = MSB_W / 2;
   localparam int HI_W    = MSB_W - LO_W;
   localparam int LINES   = unary_lines(MSB_W);
   localparam int ROW_LN  = unary_lines(HI_W);
   localparam int COL_LN  = unary_lines(LO_W);
   localparam int BIN_LAG = 2;

   if (MSB_W < 2 || MSB_W > 10) begin : g_bad_msb
      $error("MSB_W must lie in 2..10");
   end
   if (LSB_W < 1) begin : g_bad_lsb
      $error("DATA_W must exceed MSB_W");
   end

   // Stage 1: input latch
   logic [DATA_W-1:0] word_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= data_i;
   end

   logic [MSB_W-1:0] msb_w;
   assign msb_w = word_q[DATA_W-1 -: MSB_W];

   // Stage 2: per-field thermometer decode
   logic [ROW_LN-1:0] rows_d, rows_q;
   logic [COL_LN-1:0] cols_d, cols_q;

   segdec_field #(.W(HI_W)) u_rows (.code_i(msb_w[MSB_W-1 -: HI_W]), .lines_o(rows_d));
   segdec_field #(.W(LO_W)) u_cols (.code_i(msb_w[LO_W-1:0]),        .lines_o(cols_d));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rows_q <= '0;
         cols_q <= '0;
      end else begin
         rows_q <= rows_d;
         cols_q <= cols_d;
      end
   end

   // Stage 3: combine and re-align
   logic [LINES-1:0] therm_d, therm_q;
   segdec_merge #(.ROW_W(HI_W), .COL_W(LO_W)) u_merge (
      .rows_i (rows_q),
      .cols_i (cols_q),
      .lines_o(therm_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) therm_q <= '0;
      else        therm_q <= therm_d;
   end

   segdec_delay #(.WIDTH(LSB_W), .DEPTH(BIN_LAG)) u_bin_dly (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (word_q[LSB_W-1:0]),
      .q_o  (bin_o)
   );

   assign therm_o = therm_q;

   // Checks
   logic [1:0] age_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          age_q <= '0;
      else if (age_q != 3) age_q <= age_q + 2'd1;
   end

   assert_therm_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((therm_o >> 1) & ~therm_o) == '0);

   assert_unary_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
      age_q == 2'd3 |-> 32'($countones(therm_o)) == 32'($past(data_i[DATA_W-1 -: MSB_W], 3)));

   assert_binary_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
      age_q == 2'd3 |-> bin_o == $past(data_i[LSB_W-1:0], 3));

   assert_reset_clear_R6: assert property (@(posedge clk)
      !rst_n |-> (therm_o == '0 && bin_o == '0));
endmodule

// File: tb/seg_therm_decoder_bench.sv
module seg_therm_decoder_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] data_i = '0;
   logic [62:0] therm_o;
   logic [5:0]  bin_o;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   seg_therm_decoder u_seg_therm_decoder (
      .clk(clk), .rst_n(rst_n), .data_i(data_i), .therm_o(therm_o), .bin_o(bin_o)
   );

   function automatic logic [62:0] exp_therm(input logic [11:0] w);
      logic [63:0] t;
      t = (64'd1 << w[11:6]) - 64'd1;
      return t[62:0];
   endfunction

   task automatic check(input string req, input logic [11:0] w);
      vectors++;
      if (therm_o !== exp_therm(w) || bin_o !== w[5:0]) begin
         errors++;
         $display("FAIL %s: got therm=%h bin=%h expected therm=%h bin=%h",
                  req, therm_o, bin_o, exp_therm(w), w[5:0]);
      end
   endtask

   // Apply a word, sample three edges later
   task automatic apply(input string req, input logic [11:0] w);
      @(negedge clk) data_i = w;
      repeat (3) @(posedge clk);
      @(negedge clk) check(req, w);
   endtask

   task automatic t_reset();
      @(negedge clk);
      vectors++;
      if (therm_o !== '0 || bin_o !== '0) begin
         errors++;
         $display("FAIL R6: got therm=%h bin=%h expected 0 0", therm_o, bin_o);
      end
   endtask

   task automatic t_extremes();
      apply("R8 zero", 12'h000);
      apply("R8 full", 12'hFFF);
      apply("R2 one", {6'd1, 6'd0});
      apply("R2 sixty-two", {6'd62, 6'h3F});
   endtask

   task automatic t_field_split();
      for (int r = 1; r < 8; r++) begin
         apply("R1 below row step", {6'(8*r-1), 6'(r)});
         apply("R2 at row step",    {6'(8*r),   6'(63-r)});
      end
   endtask

   task automatic t_latency();
      logic [11:0] prev, nxt;
      prev = {6'd5, 6'd9};
      nxt  = {6'd40, 6'd50};
      apply("R3 settle", prev);
      @(negedge clk) data_i = nxt;
      repeat (2) @(posedge clk);
      @(negedge clk) check("R3 still old", prev);
      @(posedge clk);
      @(negedge clk) check("R5 both fields together", nxt);
   endtask

   task automatic t_stream();
      logic [11:0] hist [16];
      for (int c = 0; c < 19; c++) begin
         @(negedge clk);
         if (c >= 3) check("R7 stream", hist[c-3]);
         if (c < 16) begin
            hist[c] = 12'((c * 12'd397 + 12'd101) ^ (c << 7));
            data_i  = hist[c];
         end
      end
   endtask

   task automatic t_mid_reset();
      @(negedge clk) data_i = 12'hABC;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b0;
      #1;
      vectors++;
      if (therm_o !== '0 || bin_o !== '0) begin
         errors++;
         $display("FAIL R6 mid-run: got therm=%h bin=%h expected 0 0", therm_o, bin_o);
      end
      @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      apply("R4 after reset", 12'h5A3);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      rst_n = 1'b1;
      t_extremes();
      t_field_split();
      t_latency();
      t_stream();
      t_mid_reset();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule